// File: doc/BRIEF.md
# PLA Online Fault Diagnosis Engine

This block finds crosspoint faults in a running programmable logic array without stopping it for test patterns. A start pulse captures one live snapshot of the array: the input vector that drives the AND plane, the product-term vector between the two planes, and the output vector of the OR plane. The engine then compares this snapshot with the configuration the array should hold. That configuration sits in two small internal memories.

The AND-plane memory stores one word per input column. Bit p of that word is 1 when input column i is meant to connect to product term p. The OR-plane memory stores one word per product-term row. Bit o of that word is 1 when product term p is meant to drive output o. For every input that is low, the engine scans that input's column. For every product term that is high, it scans that term's row. Each crosspoint whose live value disagrees with its stored setting is reported as a typed fault with a row and column location. Reports leave the block one per valid/ready beat, and a single-cycle done pulse closes the run.

Top module: `pla_diag_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `rpt_valid_o` and `done_o` are all 0.
- R2: When the engine is idle, a `start_i` pulse captures `iv_i`, `ptv_i` and `ov_i`, and `busy_o` is 1 in the next cycle. A `start_i` that arrives while `busy_o` is 1 is ignored and does not change the snapshot being diagnosed.
- R3: An AND-plane column i is examined only when `iv_i[i]` is 0. For each product term p where the stored column bit is 1 and the product-term bit is 1, the engine reports kind 0 with row = i and column = p.
- R4: In the same AND-plane check, each product term p where the stored column bit is 0 and the product-term bit is 0 is reported as kind 1 with row = i and column = p.
- R5: An OR-plane row p is examined only when `ptv_i[p]` is 1. For each output o where the stored row bit is 1 and the output bit is 0, the engine reports kind 2 with row = p and column = o.
- R6: In the same OR-plane check, each output o where the stored row bit is 0 and the output bit is 1 is reported as kind 3 with row = p and column = o.
- R7: Reports come out in a fixed order. All AND-plane columns come first in ascending i, then all OR-plane rows in ascending p. Within one column or row, reports come out in ascending column index. Each report is sent exactly once.
- R8: While `rpt_valid_o` is 1 and `rpt_ready_i` is 0, the report holds: `rpt_valid_o`, `rpt_kind_o`, `rpt_row_o` and `rpt_col_o` stay unchanged in the next cycle.
- R9: `done_o` is a one-cycle pulse that follows the last accepted report, or the last examined row when there are no reports. In that cycle `busy_o` is already 0.
- R10: A configuration write is ignored while `busy_o` is 1.
- R11: When idle, a write with `cfg_plane_i` = 0 stores `cfg_data_i[N_PT-1:0]` as the AND-plane column at address `cfg_addr_i`. A write with `cfg_plane_i` = 1 stores `cfg_data_i[N_OUT-1:0]` as the OR-plane row at that address. Bit k of the stored word is the setting of crosspoint k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_plane_i | input | 1 | Selects the plane: 0 = AND plane, 1 = OR plane |
| cfg_addr_i | input | AW | Column (AND plane) or row (OR plane) to write |
| cfg_data_i | input | DW | Crosspoint settings to write, one bit per crosspoint |
| start_i | input | 1 | Captures the snapshot and starts a diagnosis run |
| iv_i | input | N_IN | Live AND-plane input vector |
| ptv_i | input | N_PT | Live product-term vector |
| ov_i | input | N_OUT | Live OR-plane output vector |
| busy_o | output | 1 | High while a diagnosis run is in progress |
| rpt_valid_o | output | 1 | A fault report is present |
| rpt_ready_i | input | 1 | The receiver accepts the report |
| rpt_kind_o | output | 2 | Fault kind: 0 G, 1 S, 2 D, 3 A |
| rpt_row_o | output | AW | Input column (AND plane) or product-term row (OR plane) of the fault |
| rpt_col_o | output | CW | Product term (AND plane) or output (OR plane) of the fault |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The assertions assume `rpt_ready_i` is a clean level that the receiver may change in any cycle. They also assume that `start_i` and `cfg_we_i` never carry X after reset. The properties on kind and location ranges hold only if the configuration addresses written stay inside the array. The stimulus keeps every configuration write inside the array and issues them only between runs, except for deliberate writes made while busy. It keeps every start pulse one cycle long, and only the deliberate extra pulses fall inside a run. It changes ready at random on each falling edge, so that stalls of every length occur both on the first report of a row and in the middle of one.

// File: rtl/pla_diag_pkg.sv
package pla_diag_pkg;

  typedef enum logic [1:0] {
    FT_G = 2'd0,
    FT_S = 2'd1,
    FT_D = 2'd2,
    FT_A = 2'd3
  } fault_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_EMIT = 2'd2
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pla_diag_cfg_mem.sv
module pla_diag_cfg_mem #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 6,
  parameter int AW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (we_i && waddr_i == AW'(e)) mem_q[e] <= wdata_i;
      end
    end
  end

  // out-of-range addresses read as all-zero
  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (raddr_i == AW'(e)) rdata_o = mem_q[e];
    end
  end

endmodule

// File: rtl/pla_diag_pick.sv
module pla_diag_pick #(
  parameter int W  = 6,
  parameter int IW = 3
) (
  input  logic [W-1:0]  mask_i,
  output logic [W-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);

  assign onehot_o = mask_i & (~mask_i + W'(1));

  always_comb begin
    idx_o = '0;
    for (int b = W - 1; b >= 0; b--) begin
      if (mask_i[b]) idx_o = IW'(b);
    end
  end

endmodule

// File: rtl/pla_diag_seq.sv
module pla_diag_seq
  import pla_diag_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_PT  = 6,
  parameter int N_OUT = 3,
  parameter int DW    = 6,
  parameter int AW    = 3,
  parameter int CW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_IN-1:0]  iv_i,
  input  logic [N_PT-1:0]  ptv_i,
  input  logic [N_OUT-1:0] ov_i,
  input  logic [N_PT-1:0]  and_pat_i,
  input  logic [N_OUT-1:0] or_pat_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             busy_o,
  output logic             rpt_valid_o,
  input  logic             rpt_ready_i,
  output logic [1:0]       rpt_kind_o,
  output logic [AW-1:0]    rpt_row_o,
  output logic [CW-1:0]    rpt_col_o,
  output logic             done_o
);

  localparam logic [DW-1:0] PT_COLS = DW'({N_PT{1'b1}});

  seq_state_e       state_q;
  logic             phase_q;  // 0: AND plane, 1: OR plane
  logic [AW-1:0]    idx_q;
  logic [N_IN-1:0]  iv_q;
  logic [N_PT-1:0]  ptv_q;
  logic [N_OUT-1:0] ov_q;
  logic [DW-1:0]    mask_q, pat_q;
  logic             done_q;

  logic [DW-1:0]    pat_now, mask_now, pick_oh, mask_left;
  logic [CW-1:0]    pick_idx;
  logic             iv_bit, pt_bit, step_on, last_step, phase_next, pick_hit;
  logic [AW-1:0]    idx_next;

  pla_diag_pick #(.W(DW), .IW(CW)) u_pick (
    .mask_i   (mask_q),
    .onehot_o (pick_oh),
    .idx_o    (pick_idx)
  );

  always_comb begin
    iv_bit = 1'b0;
    for (int j = 0; j < N_IN; j++) if (idx_q == AW'(j)) iv_bit = iv_q[j];
    pt_bit = 1'b0;
    for (int j = 0; j < N_PT; j++) if (idx_q == AW'(j)) pt_bit = ptv_q[j];

    if (!phase_q) begin
      pat_now  = DW'(and_pat_i);
      // AND fault wherever stored bit equals the live product term
      mask_now = ~(pat_now ^ DW'(ptv_q)) & PT_COLS;
      step_on  = !iv_bit;
    end else begin
      pat_now  = DW'(or_pat_i);
      mask_now = pat_now ^ DW'(ov_q);
      step_on  = pt_bit;
    end

    last_step = phase_q && (idx_q == AW'(N_PT - 1));
    if (!phase_q && idx_q == AW'(N_IN - 1)) begin
      phase_next = 1'b1;
      idx_next   = '0;
    end else begin
      phase_next = phase_q;
      idx_next   = idx_q + AW'(1);
    end
    mask_left = mask_q & ~pick_oh;
    pick_hit  = |(pat_q & pick_oh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      idx_q   <= '0;
      iv_q    <= '0;
      ptv_q   <= '0;
      ov_q    <= '0;
      mask_q  <= '0;
      pat_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            iv_q    <= iv_i;
            ptv_q   <= ptv_i;
            ov_q    <= ov_i;
            phase_q <= 1'b0;
            idx_q   <= '0;
            state_q <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (step_on && |mask_now) begin
            mask_q  <= mask_now;
            pat_q   <= pat_now;
            state_q <= ST_EMIT;
          end else if (last_step) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            phase_q <= phase_next;
            idx_q   <= idx_next;
          end
        end
        ST_EMIT: begin
          if (rpt_ready_i) begin
            mask_q <= mask_left;
            if (mask_left == '0) begin
              if (last_step) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                phase_q <= phase_next;
                idx_q   <= idx_next;
                state_q <= ST_STEP;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr_o   = idx_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign rpt_valid_o = (state_q == ST_EMIT);
  assign rpt_kind_o  = phase_q ? (pick_hit ? FT_D : FT_A) : (pick_hit ? FT_G : FT_S);
  assign rpt_row_o   = idx_q;
  assign rpt_col_o   = pick_idx;
  assign done_o      = done_q;

endmodule

// File: rtl/pla_diag_engine.sv
module pla_diag_engine
  import pla_diag_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_PT  = 6,
  parameter int N_OUT = 3,
  localparam int DW   = max2(N_PT, N_OUT),
  localparam int AW   = idx_bits(max2(N_IN, N_PT)),
  localparam int CW   = idx_bits(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_plane_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]    cfg_data_i,
  input  logic             start_i,
  input  logic [N_IN-1:0]  iv_i,
  input  logic [N_PT-1:0]  ptv_i,
  input  logic [N_OUT-1:0] ov_i,
  output logic             busy_o,
  output logic             rpt_valid_o,
  input  logic             rpt_ready_i,
  output logic [1:0]       rpt_kind_o,
  output logic [AW-1:0]    rpt_row_o,
  output logic [CW-1:0]    rpt_col_o,
  output logic             done_o
);

  logic [AW-1:0]    rd_addr;
  logic [N_PT-1:0]  and_pat;
  logic [N_OUT-1:0] or_pat;
  logic             busy;
  logic             and_we, or_we;

  assign and_we = cfg_we_i && !busy && !cfg_plane_i;
  assign or_we  = cfg_we_i && !busy &&  cfg_plane_i;

  pla_diag_cfg_mem #(.DEPTH(N_IN), .WIDTH(N_PT), .AW(AW)) u_and_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (and_we),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_data_i[N_PT-1:0]),
    .raddr_i (rd_addr),
    .rdata_o (and_pat)
  );

  pla_diag_cfg_mem #(.DEPTH(N_PT), .WIDTH(N_OUT), .AW(AW)) u_or_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (or_we),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_data_i[N_OUT-1:0]),
    .raddr_i (rd_addr),
    .rdata_o (or_pat)
  );

  pla_diag_seq #(
    .N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .DW(DW), .AW(AW), .CW(CW)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .iv_i        (iv_i),
    .ptv_i       (ptv_i),
    .ov_i        (ov_i),
    .and_pat_i   (and_pat),
    .or_pat_i    (or_pat),
    .rd_addr_o   (rd_addr),
    .busy_o      (busy),
    .rpt_valid_o (rpt_valid_o),
    .rpt_ready_i (rpt_ready_i),
    .rpt_kind_o  (rpt_kind_o),
    .rpt_row_o   (rpt_row_o),
    .rpt_col_o   (rpt_col_o),
    .done_o      (done_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/pla_diag_chk.sv
module pla_diag_chk #(
  parameter int N_IN  = 4,
  parameter int N_PT  = 6,
  parameter int N_OUT = 3,
  parameter int AW    = 3,
  parameter int CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          rpt_valid_o,
  input logic          rpt_ready_i,
  input logic [1:0]    rpt_kind_o,
  input logic [AW-1:0] rpt_row_o,
  input logic [CW-1:0] rpt_col_o,
  input logic          done_o
);

  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rpt_valid_o);

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  assert_and_loc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && !rpt_kind_o[1]) |-> (rpt_row_o < AW'(N_IN) && rpt_col_o < CW'(N_PT)));

  assert_or_loc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && rpt_kind_o[1]) |-> (rpt_row_o < AW'(N_PT) && rpt_col_o < CW'(N_OUT)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && !rpt_ready_i) |=>
      (rpt_valid_o && $stable(rpt_kind_o) && $stable(rpt_row_o) && $stable(rpt_col_o)));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

endmodule

bind pla_diag_engine pla_diag_chk #(
  .N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .AW(AW), .CW(CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .rpt_valid_o (rpt_valid_o),
  .rpt_ready_i (rpt_ready_i),
  .rpt_kind_o  (rpt_kind_o),
  .rpt_row_o   (rpt_row_o),
  .rpt_col_o   (rpt_col_o),
  .done_o      (done_o)
);

// File: tb/pla_diag_engine_bench.sv
`timescale 1ns/1ps
module pla_diag_engine_bench;

  localparam int NI = 4;
  localparam int NP = 6;
  localparam int NO = 3;
  localparam int DW = 6;
  localparam int AW = 3;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_plane = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic          start = 1'b0;
  logic [NI-1:0] iv = '0;
  logic [NP-1:0] ptv = '0;
  logic [NO-1:0] ov = '0;
  logic          busy, valid, done;
  logic          ready = 1'b0;
  logic [1:0]    kind;
  logic [AW-1:0] row;
  logic [CW-1:0] col;

  always #4 clk = ~clk;

  pla_diag_engine #(.N_IN(NI), .N_PT(NP), .N_OUT(NO)) u_pla_diag_engine (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_plane_i(cfg_plane),
    .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data), .start_i(start),
    .iv_i(iv), .ptv_i(ptv), .ov_i(ov), .busy_o(busy),
    .rpt_valid_o(valid), .rpt_ready_i(ready), .rpt_kind_o(kind),
    .rpt_row_o(row), .rpt_col_o(col), .done_o(done)
  );

  int n_chk = 0, n_fail = 0;
  logic [NP-1:0] am [NI];
  logic [NO-1:0] om [NP];
  int exp_code [64];
  int exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic int pack(input int k, input int r, input int c);
    return (k << 16) | (r << 8) | c;
  endfunction

  function automatic string req_of(input int code);
    case (code >> 16)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // expected report list in the order fixed by R7
  function automatic void build_exp(input logic [NI-1:0] v_i, input logic [NP-1:0] v_p,
                                    input logic [NO-1:0] v_o);
    exp_n = 0;
    for (int i = 0; i < NI; i++) begin
      if (!v_i[i]) begin
        for (int p = 0; p < NP; p++) begin
          if (am[i][p] == v_p[p]) begin
            exp_code[exp_n] = pack(am[i][p] ? 0 : 1, i, p);
            exp_n++;
          end
        end
      end
    end
    for (int p = 0; p < NP; p++) begin
      if (v_p[p]) begin
        for (int o = 0; o < NO; o++) begin
          if (om[p][o] != v_o[o]) begin
            exp_code[exp_n] = pack(om[p][o] ? 2 : 3, p, o);
            exp_n++;
          end
        end
      end
    end
  endfunction

  task automatic write_cfg(input bit plane, input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_plane = plane; cfg_addr = AW'(addr); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < NI; i++) write_cfg(1'b0, i, DW'(am[i]));
    for (int p = 0; p < NP; p++) write_cfg(1'b1, p, DW'(om[p]));
  endtask

  task automatic run(input logic [NI-1:0] v_i, input logic [NP-1:0] v_p,
                     input logic [NO-1:0] v_o, input int rdy_pct, input bit poke);
    int got = 0;
    bit seen_done = 0;
    bit stalled = 0;
    int held = 0;
    build_exp(v_i, v_p, v_o);
    @(negedge clk);
    start = 1'b1; iv = v_i; ptv = v_p; ov = v_o;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    for (int cyc = 0; cyc < 3000 && !seen_done; cyc++) begin
      @(negedge clk);
      ready = (($urandom % 100) < rdy_pct);
      start = 1'b0;
      cfg_we = 1'b0;
      if (poke && cyc == 1) begin
        start = 1'b1; iv = ~v_i; ptv = ~v_p; ov = ~v_o;     // R2: must be ignored
      end
      if (poke && cyc == 2) begin
        cfg_we = 1'b1; cfg_plane = 1'b0; cfg_addr = '0;    // R10: must be ignored
        cfg_data = ~DW'(am[0]);
      end
      #1;
      if (stalled)
        chk(valid === 1'b1 && pack(kind, row, col) == held, "R8", "held report",
            pack(kind, row, col), held);
      if (valid && ready) begin
        if (got < exp_n)
          chk(pack(kind, row, col) == exp_code[got], req_of(exp_code[got]),
              "report kind/row/col (order R7)", pack(kind, row, col), exp_code[got]);
        else
          chk(1'b0, "R7", "extra report", pack(kind, row, col), -1);
        got++;
      end
      stalled = valid && !ready;
      held = pack(kind, row, col);
      if (done) begin
        seen_done = 1;
        chk(got == exp_n, "R9", "reports before done", got, exp_n);
        chk(busy === 1'b0, "R9", "busy with done", int'(busy), 0);
      end
    end
    start = 1'b0; cfg_we = 1'b0; ready = 1'b0;
    chk(seen_done, "R9", "done seen", int'(seen_done), 1);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < NI; i++) am[i] = '0;
    for (int p = 0; p < NP; p++) om[p] = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && valid === 1'b0 && done === 1'b0, "R1", "reset state",
        {busy, valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && valid === 1'b0 && done === 1'b0, "R1", "idle after reset",
        {busy, valid, done}, 0);

    // nothing examined: every input high, every product term low
    run('1, '0, '0, 100, 0);
    // empty configuration, all product terms low: S faults only (R4)
    run('0, '0, '1, 100, 0);
    // empty configuration, all terms and outputs high: A faults only (R6)
    run('1, '1, '1, 70, 0);
    // full configuration through the write port (R11): G then D faults (R3, R5)
    for (int i = 0; i < NI; i++) am[i] = '1;
    for (int p = 0; p < NP; p++) om[p] = '1;
    load_all();
    run('0, '1, '0, 50, 0);

    for (int t = 0; t < 30; t++) begin
      logic [NI-1:0] ri;
      logic [NP-1:0] rp;
      logic [NO-1:0] ro;
      bit pk;
      for (int i = 0; i < NI; i++) am[i] = NP'($urandom);
      for (int p = 0; p < NP; p++) om[p] = NO'($urandom);
      load_all();
      ri = NI'($urandom); rp = NP'($urandom); ro = NO'($urandom);
      pk = (t % 3 == 0);
      run(ri, rp, ro, 20 + int'($urandom % 81), pk);
      // writes and start during the previous run must have left state intact (R10, R2)
      if (pk) run(ri, rp, ro, 100, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule